// File: doc/BRIEF.md
# Platform System Control Register File

This block is a small byte-wide register file on a simple 8-bit I/O bus. The bus carries an address, a write strobe, a read strobe, write data and registered read data. The register file holds the platform's own control state: a soft-reset request line, a little-endian mode flag, a disk-activity indicator, a 4-bit system control field and an I/O map mode bit. The map mode bit is consumed by a separate address translator elsewhere in the chip.

A group of addresses answer with fixed identification, feature and equipment bytes. A pair of adjacent ports hold two free scratch bytes. Writes to two password-protect ports produce one-cycle lock-toggle pulses toward a non-volatile memory controller.

Any access to an address the block does not decode reads back as 0xFF, changes nothing, and raises a one-cycle error pulse.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, soft_reset, little_endian, disk_led, noncontig_map, lock_pulse, bad_access and rdata are all 0, and sys_ctrl is 0.
- R2: A write to 0x0092 sets soft_reset to data bit 0 and little_endian to data bit 1 on the next clock edge; a read of 0x0092 returns 0x00.
- R3: Reads of 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0, and writes to these ports leave those values unchanged.
- R4: Reads of 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to 0x0808 sets disk_led to data bit 0.
- R6: A write to 0x081C stores data bits 3:0 in sys_ctrl and ignores bits 7:4; a read of 0x081C returns {4'b0, sys_ctrl}.
- R7: A write to 0x0850 sets noncontig_map to data bit 0 (0 = contiguous, 1 = non-contiguous); a read of 0x0850 returns {7'b0, noncontig_map}.
- R8: A write to 0x0810 drives lock_pulse[0] high, and a write to 0x0812 drives lock_pulse[1] high, for exactly the one cycle after the write strobe.
- R9: A read of an undecoded address returns 0xFF. A write to an undecoded address changes no state. Either access drives bad_access high for the one cycle after the strobe. Port 0x0814 is decoded: it reads 0xFF and ignores writes, with no error.
- R10: Ports 0x0398 and 0x0399 are two independent 8-bit scratch bytes that return the last value written.
- R11: rdata is updated on the clock edge that samples rd_en and holds its value while rd_en is low; a read in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | I/O port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| soft_reset | output | 1 | Soft-reset request |
| little_endian | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk-activity indicator |
| sys_ctrl | output | 4 | System control field |
| noncontig_map | output | 1 | I/O map mode for the address translator |
| lock_pulse | output | 2 | Lock-toggle pulses, bit 0 for port 0x0810, bit 1 for port 0x0812 |
| bad_access | output | 1 | One-cycle pulse on access to an undecoded address |

## Verification
The bench builds the block with the default ADDR_W of 16. At that width every decoded port and its near neighbours can be addressed exactly, including 0x0801 and 0x0811 between decoded ports, and 0x0851 just past the last one. Directed tasks cover each writable field with both set and clear values, and the fixed bytes before and after writes aimed at them. They also cover the pulse width of the lock and error outputs, and a read and a write issued in the same cycle.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              soft_reset,
  output logic              little_endian,
  output logic              disk_led,
  output logic [3:0]        sys_ctrl,
  output logic              noncontig_map,
  output logic [1:0]        lock_pulse,
  output logic              bad_access
);
  localparam logic [ADDR_W-1:0] P_RST  = ADDR_W'(16'h0092);
  localparam logic [ADDR_W-1:0] P_ID0  = ADDR_W'(16'h0800);
  localparam logic [ADDR_W-1:0] P_ID1  = ADDR_W'(16'h0802);
  localparam logic [ADDR_W-1:0] P_ID2  = ADDR_W'(16'h0803);
  localparam logic [ADDR_W-1:0] P_LED  = ADDR_W'(16'h0808);
  localparam logic [ADDR_W-1:0] P_EQP  = ADDR_W'(16'h080C);
  localparam logic [ADDR_W-1:0] P_LK1  = ADDR_W'(16'h0810);
  localparam logic [ADDR_W-1:0] P_LK2  = ADDR_W'(16'h0812);
  localparam logic [ADDR_W-1:0] P_INV  = ADDR_W'(16'h0814);
  localparam logic [ADDR_W-1:0] P_KEY  = ADDR_W'(16'h0818);
  localparam logic [ADDR_W-1:0] P_CTL  = ADDR_W'(16'h081C);
  localparam logic [ADDR_W-1:0] P_L2S  = ADDR_W'(16'h0823);
  localparam logic [ADDR_W-1:0] P_MAP  = ADDR_W'(16'h0850);
  localparam logic [ADDR_W-1:0] P_SC0  = ADDR_W'(16'h0398);
  localparam logic [ADDR_W-1:0] P_SC1  = ADDR_W'(16'h0399);

  logic [7:0] scratch0, scratch1;
  logic [7:0] rd_val;
  logic       rd_hit, wr_hit;

  always_comb begin
    rd_hit = 1'b1;
    rd_val = 8'hFF;
    unique case (addr)
      P_RST:   rd_val = 8'h00;
      P_ID0:   rd_val = 8'hEF;
      P_ID1:   rd_val = 8'hAD;
      P_ID2:   rd_val = 8'hE0;
      P_EQP:   rd_val = 8'h3C;
      P_LK1:   rd_val = 8'h39;
      P_INV:   rd_val = 8'hFF;
      P_KEY:   rd_val = 8'h00;
      P_CTL:   rd_val = {4'b0, sys_ctrl};
      P_L2S:   rd_val = 8'h03;
      P_MAP:   rd_val = {7'b0, noncontig_map};
      P_SC0:   rd_val = scratch0;
      P_SC1:   rd_val = scratch1;
      default: rd_hit = 1'b0;
    endcase
  end

  assign wr_hit = (addr == P_RST) || (addr == P_ID0) || (addr == P_ID1) ||
                  (addr == P_ID2) || (addr == P_LED) || (addr == P_LK1) ||
                  (addr == P_LK2) || (addr == P_INV) || (addr == P_CTL) ||
                  (addr == P_MAP) || (addr == P_SC0) || (addr == P_SC1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata         <= 8'h00;
      soft_reset    <= 1'b0;
      little_endian <= 1'b0;
      disk_led      <= 1'b0;
      sys_ctrl      <= 4'h0;
      noncontig_map <= 1'b0;
      lock_pulse    <= 2'b00;
      bad_access    <= 1'b0;
      scratch0      <= 8'h00;
      scratch1      <= 8'h00;
    end else begin
      if (rd_en) rdata <= rd_val;
      lock_pulse <= {wr_en && addr == P_LK2, wr_en && addr == P_LK1};
      bad_access <= (rd_en && !rd_hit) || (wr_en && !wr_hit);
      if (wr_en) begin
        if (addr == P_RST) begin
          soft_reset    <= wdata[0];
          little_endian <= wdata[1];
        end
        if (addr == P_LED) disk_led      <= wdata[0];
        if (addr == P_CTL) sys_ctrl      <= wdata[3:0];
        if (addr == P_MAP) noncontig_map <= wdata[0];
        if (addr == P_SC0) scratch0      <= wdata;
        if (addr == P_SC1) scratch1      <= wdata;
      end
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              soft_reset,
  input logic              little_endian,
  input logic [3:0]        sys_ctrl,
  input logic [1:0]        lock_pulse
);
  AST_RESET_FROM_P92: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == ADDR_W'(16'h0092)) |->
      (soft_reset == $past(wdata[0]) && little_endian == $past(wdata[1]))); // R2

  AST_P92_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == ADDR_W'(16'h0092)) |-> rdata == 8'h00); // R2

  AST_ID0_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == ADDR_W'(16'h0800)) |-> rdata == 8'hEF); // R3

  AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr == ADDR_W'(16'h081C)) |-> $stable(sys_ctrl)); // R6

  AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[0] |-> $past(wr_en && addr == ADDR_W'(16'h0810))); // R8

  AST_LOCK2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[1] |-> $past(wr_en && addr == ADDR_W'(16'h0812))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata)); // R11
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .soft_reset(soft_reset),
  .little_endian(little_endian), .sys_ctrl(sys_ctrl), .lock_pulse(lock_pulse)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
  localparam int ADDR_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic soft_reset, little_endian, disk_led, noncontig_map, bad_access;
  logic [3:0] sys_ctrl;
  logic [1:0] lock_pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_regs #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .soft_reset(soft_reset),
    .little_endian(little_endian), .disk_led(disk_led), .sys_ctrl(sys_ctrl),
    .noncontig_map(noncontig_map), .lock_pulse(lock_pulse), .bad_access(bad_access)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {24'b0, d}, {24'b0, exp});
  endtask

  task automatic t_reset;
    chk("R1 outputs", {soft_reset, little_endian, disk_led, noncontig_map, lock_pulse, bad_access, sys_ctrl},
        12'h000);
    chk("R1 rdata", {24'b0, rdata}, 0);
  endtask

  task automatic t_p92;
    wr(16'h0092, 8'h03);
    chk("R2 set", {30'b0, soft_reset, little_endian}, 2'b11);
    wr(16'h0092, 8'h02);
    chk("R2 reset only cleared", {30'b0, soft_reset, little_endian}, 2'b01);
    rdchk("R2 read zero", 16'h0092, 8'h00);
    wr(16'h0092, 8'h01);
    chk("R2 endian cleared", {30'b0, soft_reset, little_endian}, 2'b10);
    wr(16'h0092, 8'h00);
    chk("R2 all cleared", {30'b0, soft_reset, little_endian}, 2'b00);
  endtask

  task automatic t_ids;
    rdchk("R3 id0", 16'h0800, 8'hEF);
    rdchk("R3 id1", 16'h0802, 8'hAD);
    rdchk("R3 id2", 16'h0803, 8'hE0);
    wr(16'h0800, 8'h00); wr(16'h0802, 8'h11); wr(16'h0803, 8'h22);
    chk("R3 no error on write", {31'b0, bad_access}, 0);
    rdchk("R3 id0 after write", 16'h0800, 8'hEF);
    rdchk("R3 id1 after write", 16'h0802, 8'hAD);
    rdchk("R3 id2 after write", 16'h0803, 8'hE0);
  endtask

  task automatic t_fixed;
    rdchk("R4 equip", 16'h080C, 8'h3C);
    rdchk("R4 ext feature", 16'h0810, 8'h39);
    rdchk("R4 keylock", 16'h0818, 8'h00);
    rdchk("R4 l2 status", 16'h0823, 8'h03);
  endtask

  task automatic t_led;
    wr(16'h0808, 8'hFF);
    chk("R5 led on", {31'b0, disk_led}, 1);
    wr(16'h0808, 8'hFE);
    chk("R5 led off", {31'b0, disk_led}, 0);
  endtask

  task automatic t_ctl;
    wr(16'h081C, 8'hA5);
    chk("R6 field", {28'b0, sys_ctrl}, 4'h5);
    rdchk("R6 readback", 16'h081C, 8'h05);
    wr(16'h081C, 8'hFA);
    rdchk("R6 readback 2", 16'h081C, 8'h0A);
  endtask

  task automatic t_map;
    wr(16'h0850, 8'hFF);
    chk("R7 noncontig", {31'b0, noncontig_map}, 1);
    rdchk("R7 readback", 16'h0850, 8'h01);
    wr(16'h0850, 8'hFE);
    chk("R7 contig", {31'b0, noncontig_map}, 0);
    rdchk("R7 readback 0", 16'h0850, 8'h00);
  endtask

  task automatic t_lock;
    wr(16'h0810, 8'h00);
    chk("R8 lock1 pulse", {30'b0, lock_pulse}, 2'b01);
    @(negedge clk);
    chk("R8 lock1 one cycle", {30'b0, lock_pulse}, 2'b00);
    wr(16'h0812, 8'h55);
    chk("R8 lock2 pulse", {30'b0, lock_pulse}, 2'b10);
    @(negedge clk);
    chk("R8 lock2 one cycle", {30'b0, lock_pulse}, 2'b00);
    rdchk("R8 read no pulse", 16'h0810, 8'h39);
    chk("R8 read no pulse", {30'b0, lock_pulse}, 2'b00);
  endtask

  task automatic t_unlisted;
    logic [7:0] d;
    wr(16'h081C, 8'h06); wr(16'h0398, 8'h5A);
    rd(16'h0801, d);
    chk("R9 read ff", {24'b0, d}, 8'hFF);
    chk("R9 read err", {31'b0, bad_access}, 1);
    @(negedge clk);
    chk("R9 err one cycle", {31'b0, bad_access}, 0);
    rdchk("R9 lock2 port read ff", 16'h0812, 8'hFF);
    rdchk("R9 l2 inv read ff", 16'h0814, 8'hFF);
    chk("R9 l2 inv no err", {31'b0, bad_access}, 0);
    wr(16'h0851, 8'hFF);
    chk("R9 write err", {31'b0, bad_access}, 1);
    wr(16'h0811, 8'hFF);
    wr(16'h0399 + 16'h1, 8'hFF);
    wr(16'h0814, 8'hFF);
    chk("R9 l2 inv write no err", {31'b0, bad_access}, 0);
    chk("R9 state untouched",
        {soft_reset, little_endian, disk_led, noncontig_map, lock_pulse, sys_ctrl}, 10'h006);
    rdchk("R9 scratch untouched", 16'h0398, 8'h5A);
    rdchk("R9 map untouched", 16'h0850, 8'h00);
  endtask

  task automatic t_scratch;
    wr(16'h0398, 8'hC3); wr(16'h0399, 8'h3C);
    rdchk("R10 scratch0", 16'h0398, 8'hC3);
    rdchk("R10 scratch1", 16'h0399, 8'h3C);
    wr(16'h0399, 8'h81);
    rdchk("R10 scratch0 kept", 16'h0398, 8'hC3);
    rdchk("R10 scratch1 new", 16'h0399, 8'h81);
  endtask

  task automatic t_timing;
    rdchk("R11 prime", 16'h0800, 8'hEF);
    repeat (3) @(negedge clk);
    chk("R11 hold", {24'b0, rdata}, 8'hEF);
    @(negedge clk); addr = 16'h0398; wdata = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 old value on simultaneous", {24'b0, rdata}, 8'hC3);
    rdchk("R11 new value next read", 16'h0398, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_p92();
    t_ids();
    t_fixed();
    t_led();
    t_ctl();
    t_map();
    t_lock();
    t_unlisted();
    t_scratch();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule